// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces a signed frequency-offset word, one sample per reference clock cycle, for a downstream fractional divider or digitally controlled oscillator. It runs on the reference clock. The offset follows a fixed triangular profile that repeats every 1024 cycles, so its rate is about one thousandth of the clock rate. A 2-bit select picks the depth of the profile. Three depths are symmetric about zero (center spread). The fourth only pulls the frequency down (down spread). While spreading is off, the word is held at exactly zero, so the clock keeps its nominal unity ratio.

Offsets are in steps of 1/3200 of the nominal frequency. A one-cycle `zero_mark` pulse flags each point where the profile passes through zero. The block changes depth only at such a point, and it leaves spreading only at such a point, so the offset never jumps. Both control inputs are resynchronised with two flip-flops before the sequencer sees them.

The sequencer has three states:
- **SEQ_IDLE** holds a zero output with the phase at 0. When the synchronised enable goes active, the *start* transition moves it to SEQ_RUN at phase 0 and latches the select.
- **SEQ_RUN** advances the phase by one each cycle. At a crossing it may *relatch* the select. If the enable is inactive at a crossing, the *stop* transition returns it to SEQ_IDLE. If the enable drops between crossings, the *drain* transition moves it to SEQ_DRAIN.
- **SEQ_DRAIN** keeps advancing until the next crossing, then the *settle* transition returns it to SEQ_IDLE.

Top module: `ssc_profile_gen`

## Requirements
- R1: While the block is in its idle state (spreading off), `freq_offset` is 0 and `zero_mark` is 0. This holds for any value on `spread_sel`.
- R2: `spread_sel` encoding: 2'b00 gives a peak of ±20, 2'b01 gives ±40, 2'b10 gives ±80, and 2'b11 gives down spread with a floor of −120 and a ceiling of 0. The offset never leaves the range −120 to +80.
- R3: In center spread the phase p runs from 0 to 1023. For p in [0,256) the offset is trunc(p·peak/256). For p in [256,512) it is trunc((512−p)·peak/256). For p in [512,1024) the offset is the negation of its value at p−512.
- R4: In down spread the offset is −trunc(p·120/512) for p in [0,512), and −trunc((1024−p)·120/512) for p in [512,1024).
- R5: `zero_mark` is high for one cycle at phase 0, and also at phase 512 when the active setting is a center one. A marked cycle has an offset of 0. Consecutive marks are 512 or 1024 cycles apart.
- R6: Over one full 1024-cycle period with a fixed center setting, the offsets sum to 0.
- R7: A new select value takes effect only at a crossing. A request for down spread waits for phase 0. A request for another center depth may also take effect at phase 512. Successive offsets never differ by more than 1.
- R8: If spreading is switched off mid-period, the profile continues to its next crossing and then holds 0. When spreading is switched on again, a fresh period starts from phase 0 with the full profile.
- R9: Suppose `spread_en_n` goes low while the block is idle, before rising edge 1. Then `zero_mark` first goes high after rising edge 3, and not earlier.
- R10: During and right after reset, `freq_offset` is 0 and `zero_mark` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spread_en_n | input | 1 | Spread enable, active low, asynchronous to the block |
| spread_sel | input | 2 | Depth and mode select (encoding in R2) |
| freq_offset | output | 8 | Signed offset in steps of 1/3200 |
| zero_mark | output | 1 | One-cycle pulse at each profile zero crossing |

## Verification
Each of the four select settings is run for a full period, with the select held steady. The observed extremes, mark count and sum separate the three center depths from each other and from down spread. Select changes are applied at points that show when a change may land: mid-segment center-to-center changes land at phase 512, while a down-spread request made in the first half is held back past 512 until phase 0. Spreading is switched off in center mode and in down mode at different phases, and switched back on. This tells a correct drain to the next crossing apart from an immediate cut or an early restart. A per-cycle reference stream also checks every offset and mark against the shape formulas.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    localparam logic [1:0] SEL_NARROW = 2'b00;
    localparam logic [1:0] SEL_MEDIUM = 2'b01;
    localparam logic [1:0] SEL_WIDE   = 2'b10;
    localparam logic [1:0] SEL_DOWN   = 2'b11;

    // Peak magnitude for a center-spread select code
    function automatic logic [31:0] center_peak(
        input logic [1:0]  sel,
        input logic [31:0] pk_narrow,
        input logic [31:0] pk_medium,
        input logic [31:0] pk_wide
    );
        logic [31:0] pk;
        unique case (sel)
            SEL_NARROW: pk = pk_narrow;
            SEL_MEDIUM: pk = pk_medium;
            default:    pk = pk_wide;
        endcase
        return pk;
    endfunction

endpackage

// File: rtl/ssc_sync.sv
module ssc_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/ssc_seq.sv
module ssc_seq
    import ssc_pkg::*;
#(
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               spread_on,
    input  logic [1:0]         sel_req,
    output seq_state_e         state,
    output logic [PHASE_W-1:0] phase,
    output logic [1:0]         act_sel,
    output logic               at_cross
);
    localparam logic [PHASE_W-1:0] MID_PHASE = {1'b1, {(PHASE_W-1){1'b0}}};
    localparam logic [PHASE_W-1:0] ONE       = {{(PHASE_W-1){1'b0}}, 1'b1};

    seq_state_e         state_n;
    logic [PHASE_W-1:0] phase_n;
    logic [1:0]         act_n;
    logic               at_start;

    assign at_start = (phase == '0);
    assign at_cross = at_start || ((phase == MID_PHASE) && (act_sel != SEL_DOWN));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            phase   <= '0;
            act_sel <= SEL_NARROW;
        end else begin
            state   <= state_n;
            phase   <= phase_n;
            act_sel <= act_n;
        end
    end

    // transitions: start, relatch, stop, drain, settle
    always_comb begin
        state_n = state;
        phase_n = phase;
        act_n   = act_sel;
        unique case (state)
            SEQ_IDLE: begin
                phase_n = '0;
                if (spread_on) begin
                    state_n = SEQ_RUN;
                    act_n   = sel_req;
                end
            end
            SEQ_RUN: begin
                if (at_cross) begin
                    if (!spread_on) begin
                        state_n = SEQ_IDLE;
                        phase_n = '0;
                    end else begin
                        phase_n = phase + ONE;
                        if (at_start || (sel_req != SEL_DOWN))
                            act_n = sel_req;
                    end
                end else begin
                    phase_n = phase + ONE;
                    if (!spread_on)
                        state_n = SEQ_DRAIN;
                end
            end
            SEQ_DRAIN: begin
                if (at_cross) begin
                    state_n = SEQ_IDLE;
                    phase_n = '0;
                end else begin
                    phase_n = phase + ONE;
                end
            end
            default: begin
                state_n = SEQ_IDLE;
                phase_n = '0;
            end
        endcase
    end
endmodule

// File: rtl/ssc_shape.sv
module ssc_shape
    import ssc_pkg::*;
#(
    parameter int PHASE_W     = 10,
    parameter int OFS_W       = 8,
    parameter int PEAK_NARROW = 20,
    parameter int PEAK_MEDIUM = 40,
    parameter int PEAK_WIDE   = 80,
    parameter int DOWN_DEPTH  = 120
) (
    input  logic [PHASE_W-1:0]      phase,
    input  logic [1:0]              sel,
    output logic signed [OFS_W-1:0] value
);
    localparam int          SEG_W    = PHASE_W - 2;
    localparam int          HALF_W   = PHASE_W - 1;
    localparam logic [31:0] SEG_LEN  = 32'(1) << SEG_W;
    localparam logic [31:0] HALF_LEN = 32'(1) << HALF_W;

    logic [31:0]      pos;
    logic [31:0]      span;
    logic [31:0]      depth;
    logic [31:0]      prod;
    logic [OFS_W-1:0] mag;
    logic             neg;

    always_comb begin
        if (sel == SEL_DOWN) begin
            pos   = 32'(phase[HALF_W-1:0]);
            span  = phase[PHASE_W-1] ? (HALF_LEN - pos) : pos;
            depth = 32'(DOWN_DEPTH);
            prod  = (span * depth) >> HALF_W;
            neg   = 1'b1;
        end else begin
            pos   = 32'(phase[SEG_W-1:0]);
            span  = phase[PHASE_W-2] ? (SEG_LEN - pos) : pos;
            depth = center_peak(sel, 32'(PEAK_NARROW), 32'(PEAK_MEDIUM), 32'(PEAK_WIDE));
            prod  = (span * depth) >> SEG_W;
            neg   = phase[PHASE_W-1];
        end
        mag   = OFS_W'(prod);
        value = neg ? $signed(-mag) : $signed(mag);
    end
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
    import ssc_pkg::*;
#(
    parameter int PHASE_W     = 10,
    parameter int OFS_W       = 8,
    parameter int PEAK_NARROW = 20,
    parameter int PEAK_MEDIUM = 40,
    parameter int PEAK_WIDE   = 80,
    parameter int DOWN_DEPTH  = 120
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spread_en_n,
    input  logic [1:0]              spread_sel,
    output logic signed [OFS_W-1:0] freq_offset,
    output logic                    zero_mark
);
    logic                    en_n_s;
    logic [1:0]              sel_s;
    seq_state_e              seq_state;
    logic [PHASE_W-1:0]      seq_phase;
    logic [1:0]              seq_sel;
    logic                    seq_cross;
    logic signed [OFS_W-1:0] shape_val;

    ssc_sync #(.W(1), .RST_VAL(1'b1)) u_sync_en (
        .clk(clk), .rst_n(rst_n), .d(spread_en_n), .q(en_n_s)
    );

    ssc_sync #(.W(2), .RST_VAL(2'b00)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(spread_sel), .q(sel_s)
    );

    ssc_seq #(.PHASE_W(PHASE_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .spread_on(~en_n_s),
        .sel_req  (sel_s),
        .state    (seq_state),
        .phase    (seq_phase),
        .act_sel  (seq_sel),
        .at_cross (seq_cross)
    );

    ssc_shape #(
        .PHASE_W(PHASE_W), .OFS_W(OFS_W),
        .PEAK_NARROW(PEAK_NARROW), .PEAK_MEDIUM(PEAK_MEDIUM),
        .PEAK_WIDE(PEAK_WIDE), .DOWN_DEPTH(DOWN_DEPTH)
    ) u_shape (
        .phase(seq_phase),
        .sel  (seq_sel),
        .value(shape_val)
    );

    // output process
    always_comb begin
        unique case (seq_state)
            SEQ_RUN, SEQ_DRAIN: begin
                freq_offset = shape_val;
                zero_mark   = seq_cross;
            end
            default: begin
                freq_offset = '0;
                zero_mark   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
    import ssc_pkg::*;
#(
    parameter int PHASE_W    = 10,
    parameter int OFS_W      = 8,
    parameter int PEAK_WIDE  = 80,
    parameter int DOWN_DEPTH = 120
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [OFS_W-1:0] freq_offset,
    input logic                    zero_mark,
    input seq_state_e              seq_state
);
    localparam logic [PHASE_W:0] GAP_HALF = (PHASE_W+1)'((1 << (PHASE_W-1)) - 1);
    localparam logic [PHASE_W:0] GAP_FULL = (PHASE_W+1)'((1 << PHASE_W) - 1);

    logic [PHASE_W:0]        gap_cnt;
    logic                    gap_seen;
    logic signed [OFS_W-1:0] prev_ofs;
    logic                    prev_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            gap_seen <= 1'b0;
            prev_ofs <= '0;
            prev_ok  <= 1'b0;
        end else begin
            prev_ofs <= freq_offset;
            prev_ok  <= 1'b1;
            if (seq_state == SEQ_IDLE) begin
                gap_seen <= 1'b0;
                gap_cnt  <= '0;
            end else if (zero_mark) begin
                gap_seen <= 1'b1;
                gap_cnt  <= '0;
            end else begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE) |-> (freq_offset == '0 && !zero_mark));

    // R2
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(freq_offset) >= -DOWN_DEPTH) && (int'(freq_offset) <= PEAK_WIDE));

    // R5
    mark_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_mark |-> (freq_offset == '0));

    // R5
    mark_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_mark && gap_seen) |-> (gap_cnt == GAP_HALF || gap_cnt == GAP_FULL));

    // R7
    slew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok |-> ((int'(freq_offset) - int'(prev_ofs) <= 1) &&
                     (int'(prev_ofs) - int'(freq_offset) <= 1)));

    // R8
    drain_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_DRAIN) |=> (seq_state != SEQ_RUN));
endmodule

bind ssc_profile_gen ssc_profile_chk #(
    .PHASE_W(PHASE_W), .OFS_W(OFS_W),
    .PEAK_WIDE(PEAK_WIDE), .DOWN_DEPTH(DOWN_DEPTH)
) u_profile_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .freq_offset(freq_offset),
    .zero_mark  (zero_mark),
    .seq_state  (seq_state)
);

// File: tb/test_ssc_profile_gen.sv
module test_ssc_profile_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              spread_en_n = 1'b1;
    logic [1:0]        spread_sel = 2'b10;
    logic signed [7:0] freq_offset;
    logic              zero_mark;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ssc_profile_gen i_ssc_profile_gen (
        .clk(clk), .rst_n(rst_n), .spread_en_n(spread_en_n),
        .spread_sel(spread_sel), .freq_offset(freq_offset), .zero_mark(zero_mark)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // reference profile from R2, R3, R4
    function automatic int ref_val(input int ph, input int s);
        int pk, q, r, m;
        if (s == 3) begin
            r = ph % 512;
            m = (ph < 512) ? r : 512 - r;
            return -((m * 120) / 512);
        end
        pk = (s == 0) ? 20 : (s == 1) ? 40 : 80;
        q  = ph / 256;
        r  = ph % 256;
        m  = (q % 2 == 0) ? r : 256 - r;
        m  = (m * pk) / 256;
        return (q >= 2) ? -m : m;
    endfunction

    // scoreboard: reference model pushes one expected item per cycle
    typedef struct {
        int    ofs;
        bit    mark;
        string req;
    } exp_t;
    exp_t sbq[$];
    exp_t push_item;
    exp_t mon_item;

    int m_st, m_ph, m_act, m_s1, m_s2;
    bit m_e1, m_e2, m_on, m_bnd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ph = 0; m_act = 0;
            m_e1 = 1; m_e2 = 1; m_s1 = 0; m_s2 = 0;
            sbq.delete();
        end else begin
            m_on  = !m_e2;
            m_bnd = (m_ph == 0) || (m_ph == 512 && m_act != 3);
            case (m_st)
                0: begin
                    m_ph = 0;
                    if (m_on) begin m_st = 1; m_act = m_s2; end
                end
                1: begin
                    if (m_bnd) begin
                        if (!m_on) begin m_st = 0; m_ph = 0; end
                        else begin
                            if (m_ph == 0 || m_s2 != 3) m_act = m_s2;
                            m_ph = (m_ph + 1) % 1024;
                        end
                    end else begin
                        m_ph = (m_ph + 1) % 1024;
                        if (!m_on) m_st = 2;
                    end
                end
                default: begin
                    if (m_bnd) begin m_st = 0; m_ph = 0; end
                    else m_ph = (m_ph + 1) % 1024;
                end
            endcase
            m_e2 = m_e1; m_e1 = spread_en_n;
            m_s2 = m_s1; m_s1 = int'(spread_sel);
            push_item.ofs  = (m_st == 0) ? 0 : ref_val(m_ph, m_act);
            push_item.mark = (m_st != 0) && ((m_ph == 0) || (m_ph == 512 && m_act != 3));
            push_item.req  = (m_st == 0) ? "R1" : (m_st == 2) ? "R8" : (m_act == 3) ? "R4" : "R3";
            sbq.push_back(push_item);
        end
    end

    // monitor: pops expected items, also tracks step size (R7)
    int  prev_seen = 0;
    int  prev_val  = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_seen = 0;
        end else begin
            if (sbq.size() > 0) begin
                mon_item = sbq.pop_front();
                check(int'(freq_offset) == mon_item.ofs, mon_item.req, "offset",
                      int'(freq_offset), mon_item.ofs);
                check(zero_mark == mon_item.mark, "R5", "zero_mark",
                      int'(zero_mark), int'(mon_item.mark));
            end
            if (prev_seen != 0) begin
                check((int'(freq_offset) - prev_val <= 1) && (prev_val - int'(freq_offset) <= 1),
                      "R7", "step size", int'(freq_offset) - prev_val, 1);
            end
            prev_val  = int'(freq_offset);
            prev_seen = 1;
        end
    end

    task automatic wait_phase(input int p);
        do @(negedge clk); while (m_ph != p || m_st == 0);
    endtask

    task automatic measure(input int pk, input bit down, input string req);
        int mx, mn, sum, marks;
        wait_phase(0);
        mx = -1000; mn = 1000; sum = 0; marks = 0;
        for (int i = 0; i < 1024; i++) begin
            if (int'(freq_offset) > mx) mx = int'(freq_offset);
            if (int'(freq_offset) < mn) mn = int'(freq_offset);
            sum += int'(freq_offset);
            marks += int'(zero_mark);
            @(negedge clk);
        end
        if (down) begin
            check(mx == 0, "R4", {req, " down ceiling"}, mx, 0);
            check(mn == -120, "R2", {req, " down floor"}, mn, -120);
            check(marks == 1, "R5", {req, " marks per period"}, marks, 1);
        end else begin
            check(mx == pk, "R2", {req, " positive peak"}, mx, pk);
            check(mn == -pk, "R2", {req, " negative peak"}, mn, -pk);
            check(marks == 2, "R5", {req, " marks per period"}, marks, 2);
            check(sum == 0, "R6", {req, " period sum"}, sum, 0);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "watchdog", "run timed out", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(freq_offset == 0 && zero_mark == 0, "R10", "outputs in reset",
              int'(freq_offset), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(freq_offset == 0 && zero_mark == 0, "R10", "outputs after reset",
              int'(freq_offset), 0);

        // R1: spreading off, select set to a non-zero code
        repeat (20) @(negedge clk);
        check(freq_offset == 0, "R1", "offset while off", int'(freq_offset), 0);

        // R9: synchroniser latency
        spread_sel = 2'b00;
        repeat (3) @(negedge clk);
        spread_en_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(zero_mark == 0, "R9", "mark after 2 edges", int'(zero_mark), 0);
        @(posedge clk);
        @(negedge clk);
        check(zero_mark == 1, "R9", "mark after 3 edges", int'(zero_mark), 1);

        // narrow center spread
        measure(20, 1'b0, "R3 narrow");

        // R7: center-to-center change mid-segment lands at phase 512
        wait_phase(100);
        spread_sel = 2'b10;
        wait_phase(700);
        check(int'(freq_offset) == -58, "R7", "wide after mid crossing", int'(freq_offset), -58);
        measure(80, 1'b0, "R3 wide");

        // R7: down request waits past 512 until phase 0
        wait_phase(200);
        spread_sel = 2'b11;
        wait_phase(600);
        check(int'(freq_offset) == -27, "R7", "down held at 512", int'(freq_offset), -27);
        measure(120, 1'b1, "R4 down");
        wait_phase(300);
        check(int'(freq_offset) == -70, "R4", "down at phase 300", int'(freq_offset), -70);

        // down -> medium lands at phase 0
        wait_phase(400);
        spread_sel = 2'b01;
        wait_phase(300);
        check(int'(freq_offset) == 33, "R3", "medium at phase 300", int'(freq_offset), 33);

        // R8: disable mid-period in center mode
        spread_en_n = 1'b1;
        wait_phase(400);
        check(int'(freq_offset) == 17, "R8", "drain continues", int'(freq_offset), 17);
        repeat (300) @(negedge clk);
        check(freq_offset == 0 && zero_mark == 0, "R8", "held at zero after drain",
              int'(freq_offset), 0);

        // R8: re-enable starts a full period from phase 0
        spread_sel = 2'b10;
        repeat (3) @(negedge clk);
        spread_en_n = 1'b0;
        measure(80, 1'b0, "R8 restart");

        // R8: disable during down spread
        wait_phase(100);
        spread_sel = 2'b11;
        measure(120, 1'b1, "R4 down again");
        wait_phase(700);
        spread_en_n = 1'b1;
        wait_phase(900);
        check(int'(freq_offset) == -29, "R8", "down drain", int'(freq_offset), -29);
        repeat (200) @(negedge clk);
        check(freq_offset == 0 && zero_mark == 0, "R8", "down drain settled",
              int'(freq_offset), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule